// File: doc/BRIEF.md
# Wall-Following Maze Walker Controller

This block steers a small maze-walking robot. The robot carries two contact feelers, one on the left and one on the right. Each reads 1 while it touches something. The controller keeps the right feeler against a wall and walks along it. It drives three actuator strobes: a forward step, a small turn to the left and a small turn to the right. The plant samples these strobes once per clock cycle.

The controller is a Moore machine with four states held in a two-bit register. At reset it starts in a roaming state and walks straight until it bumps into something. It then turns left in place until it no longer touches anything. After that it alternates between two following states. One state steps while veering right to find the wall again. The other steps while veering left to move off the wall. Corners do not need a state of their own: corner handling behaves exactly like the veer-right following state and is folded into it. The present state code is brought out so that the plant or a monitor can observe it.

The feeler inputs must already be synchronous to the clock. The next-state logic can be built in one of two interchangeable forms, chosen by a parameter: a per-state case selection or flat sum-of-products equations.

Top module: `wall_follow_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a rising edge, the state becomes roaming, code 2'b00, on that edge.
- R2: In roaming (2'b00) only the forward strobe is high. The next state is backing-off (2'b01) if either feeler is 1, otherwise roaming.
- R3: In backing-off (2'b01) only the left-turn strobe is high. The state stays 2'b01 while either feeler is 1 and moves to seek-wall (2'b10) when both feelers are 0.
- R4: In seek-wall (2'b10) the forward and right-turn strobes are high and left-turn is low. The next state is veer-off (2'b11) when the right feeler is 1, otherwise 2'b10, whatever the left feeler reads.
- R5: In veer-off (2'b11) the forward and left-turn strobes are high and right-turn is low. A left feeler of 1 leads to 2'b01. Both feelers at 0 lead to 2'b10. Right feeler alone keeps 2'b11.
- R6: The actuator strobes depend on the present state only. A feeler change within a state leaves the strobes unchanged until the state itself changes.
- R7: The left-turn and right-turn strobes are never high in the same cycle.
- R8: The state output carries the present state code (roaming 2'b00, backing-off 2'b01, seek-wall 2'b10, veer-off 2'b11). Both next-state forms give the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| feel_left_i | input | 1 | Left feeler contact, 1 = touching |
| feel_right_i | input | 1 | Right feeler contact, 1 = touching |
| step_fwd_o | output | 1 | Forward step strobe |
| turn_left_o | output | 1 | Small left turn strobe |
| turn_right_o | output | 1 | Small right turn strobe |
| state_o | output | 2 | Present state code |

## Verification
A wrong state code appears at the state output and in the strobe pattern in the cycle that follows the faulty edge, because the strobes come straight from the state register with no extra register in between. A wrong transition therefore shows one clock after the feeler pattern that caused it. A wrong strobe decode shows at once in the state concerned. The bench brings the machine into every state and applies all four feeler patterns there. This covers every transition arc, including the arcs where one feeler has no effect.

// File: rtl/wall_follow_pkg.sv
package wall_follow_pkg;

   localparam int unsigned WF_STATE_W = 2;
   localparam int unsigned WF_ACT_W   = 3;

   typedef enum logic [WF_STATE_W-1:0] {
      ST_ROAM    = 2'b00,
      ST_BACKOFF = 2'b01,
      ST_SEEK    = 2'b10,
      ST_VEER    = 2'b11
   } wf_state_e;

   typedef struct packed {
      logic fwd;
      logic tl;
      logic tr;
   } wf_act_t;

   localparam wf_act_t WF_ACT_IDLE = '{fwd: 1'b0, tl: 1'b0, tr: 1'b0};

endpackage

// File: rtl/wall_follow_next.sv
module wall_follow_next
   import wall_follow_pkg::*;
#(
   parameter int unsigned STATE_W  = 2,
   parameter bit          SOP_FORM = 1'b0
) (
   input  logic [STATE_W-1:0] cur_i,
   input  logic               left_i,
   input  logic               right_i,
   output logic [STATE_W-1:0] nxt_o
);

   localparam int unsigned NUM_ST = 1 << STATE_W;

   if (STATE_W != WF_STATE_W) begin : g_bad_width
      $error("wall_follow_next: STATE_W must equal %0d", WF_STATE_W);
   end
   if (NUM_ST != 4) begin : g_bad_count
      $error("wall_follow_next: expects exactly four states");
   end

   logic any_touch;
   assign any_touch = left_i | right_i;

   if (SOP_FORM) begin : g_sop
      logic s1, s0;
      assign s1 = cur_i[1];
      assign s0 = cur_i[0];
      always_comb begin
         nxt_o    = '0;
         nxt_o[1] = (~s1 &  s0 & ~any_touch)
                  | ( s1 & ~s0)
                  | ( s1 &  s0 & ~left_i);
         nxt_o[0] = (~s1 & any_touch)
                  | ( s1 & ~s0 & right_i)
                  | ( s1 &  s0 & any_touch);
      end
   end else begin : g_case
      always_comb begin
         unique case (wf_state_e'(cur_i))
            ST_ROAM:    nxt_o = any_touch ? ST_BACKOFF : ST_ROAM;
            ST_BACKOFF: nxt_o = any_touch ? ST_BACKOFF : ST_SEEK;
            ST_SEEK:    nxt_o = right_i   ? ST_VEER    : ST_SEEK;
            ST_VEER: begin
               if (left_i)       nxt_o = ST_BACKOFF;
               else if (right_i) nxt_o = ST_VEER;
               else              nxt_o = ST_SEEK;
            end
            default:    nxt_o = ST_ROAM;
         endcase
      end
   end

endmodule

// File: rtl/wall_follow_decode.sv
module wall_follow_decode
   import wall_follow_pkg::*;
#(
   parameter int unsigned STATE_W = 2
) (
   input  logic [STATE_W-1:0] cur_i,
   output wf_act_t            act_o
);

   if (STATE_W != WF_STATE_W) begin : g_bad_width
      $error("wall_follow_decode: STATE_W must equal %0d", WF_STATE_W);
   end

   always_comb begin
      act_o = WF_ACT_IDLE;
      unique case (wf_state_e'(cur_i))
         ST_ROAM:    act_o.fwd = 1'b1;
         ST_BACKOFF: act_o.tl  = 1'b1;
         ST_SEEK: begin
            act_o.fwd = 1'b1;
            act_o.tr  = 1'b1;
         end
         ST_VEER: begin
            act_o.fwd = 1'b1;
            act_o.tl  = 1'b1;
         end
         default:    act_o = WF_ACT_IDLE;
      endcase
   end

endmodule

// File: rtl/wall_follow_reg.sv
module wall_follow_reg
   import wall_follow_pkg::*;
#(
   parameter int unsigned         STATE_W = 2,
   parameter logic [STATE_W-1:0]  INIT    = '0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [STATE_W-1:0] d_i,
   output logic [STATE_W-1:0] q_o
);

   if (STATE_W != WF_STATE_W) begin : g_bad_width
      $error("wall_follow_reg: STATE_W must equal %0d", WF_STATE_W);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) q_o <= INIT;
      else       q_o <= d_i;
   end

endmodule

// File: rtl/wall_follow_ctrl.sv
module wall_follow_ctrl
   import wall_follow_pkg::*;
#(
   parameter int unsigned STATE_W  = 2,
   parameter bit          SOP_FORM = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               feel_left_i,
   input  logic               feel_right_i,
   output logic               step_fwd_o,
   output logic               turn_left_o,
   output logic               turn_right_o,
   output logic [STATE_W-1:0] state_o
);

   localparam logic [STATE_W-1:0] START_CODE = STATE_W'(ST_ROAM);

   if (STATE_W != WF_STATE_W) begin : g_bad_width
      $error("wall_follow_ctrl: STATE_W must equal %0d", WF_STATE_W);
   end

   logic [STATE_W-1:0] cur_q;
   logic [STATE_W-1:0] nxt_d;
   wf_act_t            act;

   wall_follow_reg #(
      .STATE_W (STATE_W),
      .INIT    (START_CODE)
   ) u_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (nxt_d),
      .q_o   (cur_q)
   );

   wall_follow_next #(
      .STATE_W  (STATE_W),
      .SOP_FORM (SOP_FORM)
   ) u_next (
      .cur_i   (cur_q),
      .left_i  (feel_left_i),
      .right_i (feel_right_i),
      .nxt_o   (nxt_d)
   );

   wall_follow_decode #(
      .STATE_W (STATE_W)
   ) u_dec (
      .cur_i (cur_q),
      .act_o (act)
   );

   assign step_fwd_o   = act.fwd;
   assign turn_left_o  = act.tl;
   assign turn_right_o = act.tr;
   assign state_o      = cur_q;

endmodule

// File: rtl/wall_follow_chk.sv
module wall_follow_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       feel_left_i,
   input logic       feel_right_i,
   input logic       step_fwd_o,
   input logic       turn_left_o,
   input logic       turn_right_o,
   input logic [1:0] state_o
);

   AST_RESET_ROAM: assert property (@(posedge clk_i) rst_i |=> (state_o == 2'b00)); // R1

   AST_ROAM_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b00) |=> (state_o == ($past(feel_left_i | feel_right_i) ? 2'b01 : 2'b00))); // R2

   AST_ROAM_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b00) |-> (step_fwd_o && !turn_left_o && !turn_right_o)); // R2

   AST_BACKOFF_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b01) |=> (state_o == ($past(feel_left_i | feel_right_i) ? 2'b01 : 2'b10))); // R3

   AST_BACKOFF_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b01) |-> (!step_fwd_o && turn_left_o && !turn_right_o)); // R3

   AST_SEEK_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b10) |=> (state_o == ($past(feel_right_i) ? 2'b11 : 2'b10))); // R4

   AST_SEEK_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b10) |-> (step_fwd_o && !turn_left_o && turn_right_o)); // R4

   AST_VEER_LEFT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b11 && feel_left_i) |=> (state_o == 2'b01)); // R5

   AST_VEER_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b11 && !feel_left_i && feel_right_i) |=> (state_o == 2'b11)); // R5

   AST_VEER_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b11 && !feel_left_i && !feel_right_i) |=> (state_o == 2'b10)); // R5

   AST_VEER_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 2'b11) |-> (step_fwd_o && turn_left_o && !turn_right_o)); // R5

   AST_MOORE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      $stable(state_o) |-> ($stable(step_fwd_o) && $stable(turn_left_o) && $stable(turn_right_o))); // R6

   AST_TURN_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones({turn_left_o, turn_right_o}) <= 1); // R7

   AST_CODE_KNOWN: assert property (@(posedge clk_i) disable iff (rst_i)
      !$isunknown(state_o)); // R8

endmodule

bind wall_follow_ctrl wall_follow_chk u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .feel_left_i  (feel_left_i),
   .feel_right_i (feel_right_i),
   .step_fwd_o   (step_fwd_o),
   .turn_left_o  (turn_left_o),
   .turn_right_o (turn_right_o),
   .state_o      (state_o)
);

// File: tb/wall_follow_ctrl_bench.sv
`timescale 1ns/1ps
module wall_follow_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fl  = 1'b0;
   logic       fr  = 1'b0;
   logic       fwd, tl, tr;
   logic [1:0] st;
   logic       fwd_s, tl_s, tr_s;
   logic [1:0] st_s;

   int n_vec  = 0;
   int n_miss = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wall_follow_ctrl u_wall_follow_ctrl (
      .clk_i        (clk),
      .rst_i        (rst),
      .feel_left_i  (fl),
      .feel_right_i (fr),
      .step_fwd_o   (fwd),
      .turn_left_o  (tl),
      .turn_right_o (tr),
      .state_o      (st)
   );

   // Same machine with the sum-of-products next-state form, for R8
   wall_follow_ctrl #(.SOP_FORM(1'b1)) u_sop (
      .clk_i        (clk),
      .rst_i        (rst),
      .feel_left_i  (fl),
      .feel_right_i (fr),
      .step_fwd_o   (fwd_s),
      .turn_left_o  (tl_s),
      .turn_right_o (tr_s),
      .state_o      (st_s)
   );

   // Expected next state, written from R2..R5
   function automatic logic [1:0] exp_next(logic [1:0] s, logic l, logic r);
      case (s)
         2'b00:   return (l || r) ? 2'b01 : 2'b00;
         2'b01:   return (l || r) ? 2'b01 : 2'b10;
         2'b10:   return r ? 2'b11 : 2'b10;
         default: return l ? 2'b01 : (r ? 2'b11 : 2'b10);
      endcase
   endfunction

   // Expected strobes {fwd, tl, tr}, written from R2..R5
   function automatic logic [2:0] exp_act(logic [1:0] s);
      case (s)
         2'b00:   return 3'b100;
         2'b01:   return 3'b010;
         2'b10:   return 3'b101;
         default: return 3'b110;
      endcase
   endfunction

   task automatic check(string req, logic [1:0] exp_s);
      logic [2:0] ea;
      ea = exp_act(exp_s);
      n_vec++;
      if (st !== exp_s) begin
         n_miss++;
         $display("FAIL %s state: got %b expected %b", req, st, exp_s);
      end
      if ({fwd, tl, tr} !== ea) begin
         n_miss++;
         $display("FAIL %s strobes fwd/tl/tr: got %b expected %b", req, {fwd, tl, tr}, ea);
      end
      if (tl && tr) begin
         n_miss++;
         $display("FAIL R7 both turns high: got 11 expected at most one");
      end
      if (st_s !== st || {fwd_s, tl_s, tr_s} !== {fwd, tl, tr}) begin
         n_miss++;
         $display("FAIL R8 forms differ: got %b/%b expected %b/%b",
                  st_s, {fwd_s, tl_s, tr_s}, st, {fwd, tl, tr});
      end
   endtask

   // Drive feelers at a falling edge and sample one cycle later, past the rising edge
   task automatic step(logic l, logic r);
      @(negedge clk);
      fl = l;
      fr = r;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      fl  = 1'b0;
      fr  = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic goto_state(logic [1:0] s);
      do_reset();
      if (s != 2'b00) step(1'b1, 1'b0);
      if (s == 2'b10 || s == 2'b11) step(1'b0, 1'b0);
      if (s == 2'b11) step(1'b0, 1'b1);
      check("setup", s);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", 2'b00);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      // reset held while feelers touch: must still land in roaming
      @(negedge clk);
      rst = 1'b1;
      fl  = 1'b1;
      fr  = 1'b1;
      @(negedge clk);
      check("R1", 2'b00);
      rst = 1'b0;
      fl  = 1'b0;
      fr  = 1'b0;
   endtask

   task automatic t_roam();
      do_reset();
      step(1'b0, 1'b0); check("R2", 2'b00);
      step(1'b0, 1'b0); check("R2", 2'b00);
      step(1'b0, 1'b1); check("R2", 2'b01);
      goto_state(2'b00);
      step(1'b1, 1'b0); check("R2", 2'b01);
   endtask

   task automatic t_backoff();
      goto_state(2'b01);
      step(1'b1, 1'b1); check("R3", 2'b01);
      step(1'b0, 1'b1); check("R3", 2'b01);
      step(1'b1, 1'b0); check("R3", 2'b01);
      step(1'b0, 1'b0); check("R3", 2'b10);
   endtask

   task automatic t_seek();
      goto_state(2'b10);
      step(1'b1, 1'b0); check("R4 left ignored", 2'b10);
      step(1'b0, 1'b0); check("R4", 2'b10);
      step(1'b1, 1'b1); check("R4", 2'b11);
   endtask

   task automatic t_veer();
      goto_state(2'b11);
      step(1'b0, 1'b1); check("R5 hold", 2'b11);
      step(1'b0, 1'b0); check("R5 clear", 2'b10);
      goto_state(2'b11);
      step(1'b1, 1'b1); check("R5 left", 2'b01);
      goto_state(2'b11);
      step(1'b1, 1'b0); check("R5 left", 2'b01);
   endtask

   // R6: in seek-wall, toggle the left feeler mid-cycle; strobes must not move
   task automatic t_moore();
      goto_state(2'b10);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         fl = i[0];
         fr = 1'b0;
         #2;
         check("R6", 2'b10);
         @(posedge clk);
         #1;
         check("R6", 2'b10);
      end
   endtask

   // R8: every state against every feeler pattern, expected from the model
   task automatic t_sweep();
      for (int s = 0; s < 4; s++) begin
         for (int p = 0; p < 4; p++) begin
            goto_state(2'(s));
            step(p[1], p[0]);
            check("R8 sweep", exp_next(2'(s), p[1], p[0]));
         end
      end
   endtask

   // A long walk along a wall with a corner
   task automatic t_walk();
      logic [1:0] m;
      logic [1:0] pat [12] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b01,
                               2'b01, 2'b00, 2'b10, 2'b00, 2'b01, 2'b00};
      do_reset();
      m = 2'b00;
      foreach (pat[i]) begin
         step(pat[i][1], pat[i][0]);
         m = exp_next(m, pat[i][1], pat[i][0]);
         check("R7 walk", m);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_roam();
      t_backoff();
      t_seek();
      t_veer();
      t_moore();
      t_sweep();
      t_walk();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #1600000;
      if (!done) begin
         n_miss++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

endmodule